// File: doc/BRIEF.md
# Two-Wire Register Slave with Commit Stretching

This block is a two-wire (I2C) slave that exposes a 256-entry byte register bank to an external controller. The 7-bit device address is fixed by a strap input sampled while reset is asserted. A controller writes by sending the device address, a subaddress and one or more data bytes. The subaddress then advances after every data byte. To read, the controller first writes only a subaddress and ends with STOP. It then opens a read transaction in which the slave returns consecutive registers until the controller answers a byte with NACK.

After it acknowledges a data byte aimed at the lower part of the map (00h–8Fh), the slave holds SCL low for a programmable number of system clocks while the write commits. Bytes aimed at 90h–FFh are never stretched. Both pins pass through two synchronising flip-flops and a stability filter before an edge detector. A controller (link) state machine decodes the protocol. Its states are IDLE, DEV (shift the address byte), DEV_ACK, SUB (shift the subaddress), SUB_ACK, WDATA (shift a data byte), WACK, COMMIT (hold SCL low), RDATA (shift a byte out), RACK (sample the controller's answer) and SKIP (wait for the next START).

The transitions are as follows:
- START in any state → DEV.
- STOP in any state → IDLE.
- DEV → DEV_ACK when the address matches, otherwise DEV → SKIP.
- DEV_ACK → SUB on a write, or DEV_ACK → RDATA on a read.
- SUB → SUB_ACK → WDATA.
- WDATA → WACK.
- WACK → COMMIT for a low-map byte, or WACK → WDATA for a high-map byte.
- COMMIT → WDATA once the count expires.
- RDATA → RACK.
- RACK → RDATA on ACK, or RACK → SKIP on NACK.

A second, asynchronous read port lets the core observe the bank.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The address strap is captured only while rst_n is low. A high strap selects 7-bit address 5Dh (write byte BAh, read byte BBh) and a low strap selects 5Ch (B8h/B9h). Later strap changes have no effect.
- R2: An address byte that matches gets an ACK (SDA pulled low in the ninth clock). Any other address gets no ACK, and the slave ignores all bytes until the next START.
- R3: In a write, the first byte after the address is the subaddress and every following data byte goes to the current subaddress. The subaddress then increments, wrapping from FFh to 00h.
- R4: A read transaction returns the register at the subaddress set by a preceding write. Each further byte comes from the next subaddress, MSB first.
- R5: When the controller answers a read byte with ACK the next byte follows. When it answers with NACK the slave releases SDA and sends nothing more.
- R6: After the ACK clock of a data byte written to 00h–8Fh, the slave holds SCL low for COMMIT_CYCLES system clocks and never longer, with SDA released.
- R7: A data byte written to 90h–FFh causes no SCL stretching.
- R8: Registers 80h–8Fh are read-only: 80h=51h, 81h=50h, 82h=03h, 83h=21h, 84h–8Fh=00h. Writes to them are ignored.
- R9: Register 28h holds only bits 3:0. Its bits 7:4 always read 0.
- R10: After reset, SCL and SDA are released and all writable registers read 00h.
- R11: The core read port returns the same content that an I2C read of the same subaddress returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; strap is sampled while low |
| addr_sel_i | input | 1 | Device address strap |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low (ACK or read data 0) |
| core_raddr_i | input | 8 | Core-side read address |
| core_rdata_o | output | 8 | Core-side read data |

## Verification
The hardest situations to reach from the ports are the ones where two transactions interact. One is the subaddress pointer wrapping from FFh to 00h in the middle of a burst. The other is a read that must pick up a pointer left behind by an earlier write transaction. The bench starts a three-byte burst at FEh and then reads three bytes back from FEh, so both the wrap and the two-phase read are exercised together. Stretch length is measured by a bench controller that models open-drain lines. It releases SCL and counts the clocks until the line really rises.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    localparam int BYTE_W = 8;
    localparam int DEV_W  = 7;

    // Upper six address bits; the strap supplies bit 0.
    localparam logic [DEV_W-1:0] DEV_BASE = 7'h5C;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WACK,
        ST_COMMIT,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } link_state_e;

    // Fixed content of the read-only identification block.
    function automatic logic [BYTE_W-1:0] ro_value(input logic [BYTE_W-1:0] a);
        case (a)
            8'h80:   return 8'h51;
            8'h81:   return 8'h50;
            8'h82:   return 8'h03;
            8'h83:   return 8'h21;
            default: return 8'h00;
        endcase
    endfunction

    // Bits a write may change; zero mask marks a read-only entry.
    function automatic logic [BYTE_W-1:0] wr_mask(input logic [BYTE_W-1:0] a);
        if (a[7:4] == 4'h8)      return 8'h00;
        else if (a == 8'h28)     return 8'h0F;
        else                     return 8'hFF;
    endfunction

endpackage

// File: rtl/i2c_pin_filter.sv
module i2c_pin_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pin_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            stab_q <= '0;
            pin_o  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], pin_i};
            if (sync_q[1] == pin_o) begin
                stab_q <= '0;
            end else if (stab_q == CW'(FILT_LEN - 1)) begin
                pin_o  <= sync_q[1];
                stab_q <= '0;
            end else begin
                stab_q <= stab_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_rf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_a_i,
    output logic [BYTE_W-1:0] rdata_a_o,
    input  logic [AW-1:0]     raddr_b_i,
    output logic [BYTE_W-1:0] rdata_b_o
);
    localparam int DEPTH = 1 << AW;

    logic [BYTE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i & wr_mask(waddr_i);
        end
    end

    function automatic logic [BYTE_W-1:0] view(input logic [AW-1:0] a,
                                               input logic [BYTE_W-1:0] d);
        if (wr_mask(a) == '0) return ro_value(a);
        else                  return d & wr_mask(a);
    endfunction

    assign rdata_a_o = view(raddr_a_i, mem_q[raddr_a_i]);
    assign rdata_b_o = view(raddr_b_i, mem_q[raddr_b_i]);

endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
    import i2c_rf_pkg::*;
#(
    parameter int              COMMIT_CYCLES = 8000,
    parameter logic [BYTE_W-1:0] LOW_LIMIT   = 8'h90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic [DEV_W-1:0]  dev_addr_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [BYTE_W-1:0] ptr_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              sda_oe_o,
    output logic              scl_oe_o
);
    localparam int WCW = $clog2(COMMIT_CYCLES + 1);

    link_state_e       state_q, state_d;
    logic [3:0]        cnt_q, cnt_d;
    logic [BYTE_W-1:0] sh_q, sh_d;
    logic [BYTE_W-1:0] tx_q, tx_d;
    logic [BYTE_W-1:0] ptr_q, ptr_d;
    logic [WCW-1:0]    wait_q, wait_d;
    logic              rw_q, rw_d;
    logic              mack_q, mack_d;
    logic              low_q, low_d;
    logic              scl_d1, sda_d1;
    logic              wr_en;

    wire scl_rise = scl_f & ~scl_d1;
    wire scl_fall = ~scl_f & scl_d1;
    wire start_ev = scl_f & scl_d1 & sda_d1 & ~sda_f;
    wire stop_ev  = scl_f & scl_d1 & ~sda_d1 & sda_f;

    // Next state and datapath
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sh_d    = sh_q;
        tx_d    = tx_q;
        ptr_d   = ptr_q;
        wait_d  = wait_q;
        rw_d    = rw_q;
        mack_d  = mack_q;
        low_d   = low_q;
        wr_en   = 1'b0;
        if (start_ev) begin
            state_d = ST_DEV;
            cnt_d   = '0;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: ;
                ST_DEV, ST_SUB, ST_WDATA: begin
                    if (scl_rise) begin
                        sh_d  = {sh_q[BYTE_W-2:0], sda_f};
                        cnt_d = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == 4'd8) begin
                        cnt_d = '0;
                        if (state_q == ST_DEV) begin
                            if (sh_q[7:1] == dev_addr_i) begin
                                rw_d    = sh_q[0];
                                state_d = ST_DEV_ACK;
                            end else begin
                                state_d = ST_SKIP;
                            end
                        end else if (state_q == ST_SUB) begin
                            ptr_d   = sh_q;
                            state_d = ST_SUB_ACK;
                        end else begin
                            wr_en   = 1'b1;
                            low_d   = (ptr_q < LOW_LIMIT);
                            ptr_d   = ptr_q + 1'b1;
                            state_d = ST_WACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        if (rw_q) begin
                            tx_d    = rd_data_i;
                            ptr_d   = ptr_q + 1'b1;
                            cnt_d   = '0;
                            state_d = ST_RDATA;
                        end else begin
                            state_d = ST_SUB;
                        end
                    end
                end
                ST_SUB_ACK: begin
                    if (scl_fall) state_d = ST_WDATA;
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        if (low_q) begin
                            wait_d  = '0;
                            state_d = ST_COMMIT;
                        end else begin
                            state_d = ST_WDATA;
                        end
                    end
                end
                ST_COMMIT: begin
                    if (wait_q == WCW'(COMMIT_CYCLES - 1)) state_d = ST_WDATA;
                    else                                   wait_d  = wait_q + 1'b1;
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (cnt_q == 4'd7) begin
                            cnt_d   = '0;
                            state_d = ST_RACK;
                        end else begin
                            tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack_d = sda_f;
                    end else if (scl_fall) begin
                        if (!mack_q) begin
                            tx_d    = rd_data_i;
                            ptr_d   = ptr_q + 1'b1;
                            state_d = ST_RDATA;
                        end else begin
                            state_d = ST_SKIP;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            tx_q    <= '0;
            ptr_q   <= '0;
            wait_q  <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b1;
            low_q   <= 1'b0;
            scl_d1  <= 1'b1;
            sda_d1  <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
            tx_q    <= tx_d;
            ptr_q   <= ptr_d;
            wait_q  <= wait_d;
            rw_q    <= rw_d;
            mack_q  <= mack_d;
            low_q   <= low_d;
            scl_d1  <= scl_f;
            sda_d1  <= sda_f;
        end
    end

    // Outputs
    always_comb begin
        sda_oe_o  = (state_q == ST_DEV_ACK) || (state_q == ST_SUB_ACK) ||
                    (state_q == ST_WACK) || (state_q == ST_RDATA && !tx_q[7]);
        scl_oe_o  = (state_q == ST_COMMIT);
        wr_en_o   = wr_en;
        wr_addr_o = ptr_q;
        wr_data_o = sh_q;
        ptr_o     = ptr_q;
    end

    // Checks
    localparam int SRW = $clog2(COMMIT_CYCLES + 3) + 1;
    logic [SRW-1:0] stretch_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 stretch_run_q <= '0;
        else if (!scl_oe_o)         stretch_run_q <= '0;
        else if (stretch_run_q != '1) stretch_run_q <= stretch_run_q + 1'b1;
    end

    // R6
    stretch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_run_q <= SRW'(COMMIT_CYCLES));

    // R7
    high_no_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_addr_o >= LOW_LIMIT) |=> !scl_oe_o);

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> ptr_o == $past(ptr_o) + 8'd1);

    // R5
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RACK && scl_fall && mack_q && !start_ev && !stop_ev) |=> !sda_oe_o);

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
    import i2c_rf_pkg::*;
#(
    parameter int COMMIT_CYCLES = 8000,
    parameter int FILT_LEN      = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_sel_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o,
    input  logic [7:0] core_raddr_i,
    output logic [7:0] core_rdata_o
);
    localparam int NPIN = 2;

    logic [NPIN-1:0] pin_raw, pin_flt;
    logic            dev_sel_q;
    logic [7:0]      ptr, wr_addr, wr_data, rd_data;
    logic            wr_en;

    assign pin_raw = {scl_i, sda_i};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        i2c_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (pin_raw[g]),
            .pin_o (pin_flt[g])
        );
    end

    // Strap captured only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) dev_sel_q <= addr_sel_i;
    end

    i2c_link_fsm #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_f      (pin_flt[1]),
        .sda_f      (pin_flt[0]),
        .dev_addr_i ({DEV_BASE[DEV_W-1:1], dev_sel_q}),
        .rd_data_i  (rd_data),
        .ptr_o      (ptr),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .sda_oe_o   (sda_oe_o),
        .scl_oe_o   (scl_oe_o)
    );

    i2c_reg_bank #(.AW(8)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (wr_en),
        .waddr_i   (wr_addr),
        .wdata_i   (wr_data),
        .raddr_a_i (ptr),
        .rdata_a_o (rd_data),
        .raddr_b_i (core_raddr_i),
        .rdata_b_o (core_rdata_o)
    );

    // R1
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(dev_sel_q));

endmodule

// File: tb/i2c_regfile_slave_tb.sv
module i2c_regfile_slave_tb;

    localparam int COMMIT_T = 200;
    localparam int Q        = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_oe, sda_oe;
    logic [7:0] core_raddr = '0;
    logic [7:0] core_rdata;
    logic scl_line, sda_line;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    i2c_regfile_slave #(.COMMIT_CYCLES(COMMIT_T), .FILT_LEN(3)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_sel_i   (strap),
        .scl_i        (scl_line),
        .sda_i        (sda_line),
        .scl_oe_o     (scl_oe),
        .sda_oe_o     (sda_oe),
        .core_raddr_i (core_raddr),
        .core_rdata_o (core_rdata)
    );

    int checks = 0, failures = 0;
    int g_stretch = 0;
    logic [7:0] rb [4];
    bit done = 0;

    // {subaddress, data written, expected read-back}
    localparam logic [23:0] VEC [8] = '{
        {8'h10, 8'hA5, 8'hA5},
        {8'h90, 8'h3C, 8'h3C},
        {8'h80, 8'h00, 8'h51},
        {8'h81, 8'hFF, 8'h50},
        {8'h28, 8'hFF, 8'h0F},
        {8'hFF, 8'h77, 8'h77},
        {8'h8F, 8'h12, 8'h00},
        {8'h00, 8'h5A, 8'h5A}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic scl_high();
        int n = 0;
        scl_m = 1'b1;
        #1;
        while (!scl_line) begin
            @(posedge clk);
            #1;
            n++;
        end
        g_stretch = n;
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; idle(Q);
        scl_high();   idle(Q);
        sda_m = 1'b0; idle(Q);
        scl_m = 1'b0; idle(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; idle(Q);
        scl_high();   idle(Q);
        sda_m = 1'b1; idle(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; idle(Q);
            scl_high();   idle(Q);
            scl_m = 1'b0; idle(Q);
        end
        sda_m = 1'b1; idle(Q);
        scl_high();   idle(Q / 2);
        ack = !sda_line;
        idle(Q / 2);
        scl_m = 1'b0; idle(Q);
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            idle(Q);
            scl_high(); idle(Q / 2);
            b = {b[6:0], sda_line};
            idle(Q / 2);
            scl_m = 1'b0;
        end
        idle(Q);
        sda_m = nack; idle(Q);
        scl_high();   idle(Q);
        scl_m = 1'b0; idle(Q);
    endtask

    task automatic wr_regs(input logic [6:0] dev, input logic [7:0] sub,
                           input logic [7:0] d0, input int n, output bit ack_dev);
        bit a;
        i2c_start();
        send_byte({dev, 1'b0}, ack_dev);
        send_byte(sub, a);
        for (int i = 0; i < n; i++) send_byte(d0 + 8'(i * 8'h11), a);
        i2c_stop();
    endtask

    task automatic rd_regs(input logic [6:0] dev, input logic [7:0] sub, input int n);
        bit a;
        i2c_start();
        send_byte({dev, 1'b0}, a);
        send_byte(sub, a);
        i2c_stop();
        i2c_start();
        send_byte({dev, 1'b1}, a);
        for (int i = 0; i < n; i++) recv_byte(i == n - 1, rb[i]);
        i2c_stop();
    endtask

    task automatic wr_one(input logic [7:0] sub, input logic [7:0] d);
        bit a;
        i2c_start();
        send_byte(8'hBA, a);
        send_byte(sub, a);
        send_byte(d, a);
        i2c_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit a;
        idle(10);
        rst_n = 1'b1;
        idle(10);

        // R10: released lines and cleared bank after reset
        check(sda_oe == 1'b0 && scl_oe == 1'b0, "R10 lines released", {scl_oe, sda_oe}, 0);
        core_raddr = 8'h10; #1;
        check(core_rdata == 8'h00, "R10 reset content", core_rdata, 8'h00);
        core_raddr = 8'h80; #1;
        check(core_rdata == 8'h51, "R8 id at reset", core_rdata, 8'h51);

        // Table: write, stretch, read back, core view (R3 R4 R6 R7 R8 R9 R11)
        for (int v = 0; v < 8; v++) begin
            logic [7:0] sub, dat, exp;
            {sub, dat, exp} = VEC[v];
            wr_one(sub, dat);
            if (sub < 8'h90)
                check(g_stretch >= COMMIT_T / 2 && g_stretch <= COMMIT_T, "R6 stretch low map",
                      g_stretch, COMMIT_T);
            else
                check(g_stretch == 0, "R7 no stretch high map", g_stretch, 0);
            rd_regs(7'h5D, sub, 1);
            check(rb[0] == exp, "R4 R8 R9 read back", rb[0], exp);
            core_raddr = sub; #1;
            check(core_rdata == exp, "R11 core port", core_rdata, exp);
        end

        // R3 burst with wrap, R4 multi-byte read, R5 NACK release
        wr_regs(7'h5D, 8'hFE, 8'h11, 3, a);
        check(a, "R2 address ack", a, 1);
        rd_regs(7'h5D, 8'hFE, 3);
        check(rb[0] == 8'h11, "R3 burst FE", rb[0], 8'h11);
        check(rb[1] == 8'h22, "R3 burst FF", rb[1], 8'h22);
        check(rb[2] == 8'h33, "R3 wrap to 00", rb[2], 8'h33);
        check(sda_oe == 1'b0, "R5 SDA released after NACK", sda_oe, 0);
        rd_regs(7'h5D, 8'h10, 2);
        check(rb[0] == 8'hA5 && rb[1] == 8'h00, "R5 ACK continues", {rb[0], rb[1]}, 16'hA500);

        // R2 wrong address ignored until START
        i2c_start();
        send_byte(8'hB8, a);
        check(!a, "R2 mismatch no ack", a, 0);
        send_byte(8'h10, a);
        check(!a && sda_oe == 1'b0, "R2 skip holds off", a, 0);
        send_byte(8'hEE, a);
        i2c_stop();
        core_raddr = 8'h10; #1;
        check(core_rdata == 8'hA5, "R2 no write when skipped", core_rdata, 8'hA5);

        // R1 strap change after reset has no effect
        strap = 1'b0;
        idle(5);
        wr_regs(7'h5D, 8'h95, 8'h44, 1, a);
        check(a, "R1 strap ignored after reset", a, 1);

        // R1 strap low at reset selects 5Ch
        rst_n = 1'b0; idle(5); rst_n = 1'b1; idle(10);
        core_raddr = 8'h95; #1;
        check(core_rdata == 8'h00, "R10 cleared by reset", core_rdata, 8'h00);
        wr_regs(7'h5C, 8'h20, 8'h66, 1, a);
        check(a, "R1 low strap address acks", a, 1);
        wr_regs(7'h5D, 8'h21, 8'h66, 1, a);
        check(!a, "R1 high address refused", a, 0);
        core_raddr = 8'h20; #1;
        check(core_rdata == 8'h66, "R1 write via low address", core_rdata, 8'h66);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule